// File: doc/BRIEF.md
# DMA Channel Programming Front End

This block is the register front end of a multi-channel DMA controller. Software reaches it through two byte-wide I/O locations. A byte written to the command location chooses an operation and a channel. Bytes then written to the execute location load that channel's settings one byte at a time: the memory address, the transfer count, the peripheral port and the mode. Execute-location reads return the current address or the remaining count of the selected channel, least significant byte first.

Each channel holds a 24-bit address, a 16-bit count (transfer length minus one), a 16-bit peripheral port, four mode flags and a mask bit. A per-channel step strobe stands in for the data engine. On each step an unmasked, enabled channel advances its address by one byte or one 16-bit unit and decrements its count. When the count wraps below zero, the channel pulses terminal count and masks itself. A selector port shows one channel's port and mode settings to the data engine.

Top module: `dmaProgTop`

## Requirements
- R1: Writes and reads take effect only at I/O address 0x18 (command) and 0x1A (execute). Accesses at any other address change nothing, including the execute byte pointer.
- R2: A command byte carries the opcode in bits 7:4 and the channel in bits 3:0. A channel number of NUM_CH or more selects no channel, and execute bytes that follow it change no channel.
- R3: Opcode 0x2 loads the address from three execute writes, bits 7:0 then 15:8 then 23:16. Opcode 0x3 returns the address in the same byte order through execute reads.
- R4: Opcode 0x4 loads the 16-bit count from two execute writes, low byte first. Opcode 0x5 returns it in the same order.
- R5: Opcode 0x0 loads the 16-bit peripheral port from two execute writes, low then high. The port appears on svcPort when that channel is selected on svcSel.
- R6: Opcode 0x7 loads the mode from one execute write: bit 2 enable, bit 3 read (1) or write (0), bit 0 I/O-port mode, bit 6 16-bit units. These appear on svcEnable, svcRead, svcIoMode and svcWide.
- R7: Opcode 0x9 masks the addressed channel and opcode 0xA unmasks it, both at the command write. chMasked shows the mask bits.
- R8: Every command write restarts the byte sequence at the first byte. Execute writes beyond the operation's length are ignored. Execute reads beyond it, or under an opcode that returns nothing, give 0x00.
- R9: A step on an unmasked channel with the enable mode bit set adds 1 to the address, or 2 in 16-bit mode, and subtracts 1 from the count. A step on a masked or disabled channel changes nothing.
- R10: A step taken at count zero sets the count to 0xFFFF, masks the channel and raises tcPulse for that channel for exactly one cycle after the step.
- R11: Opcodes 0x1, 0x6, 0x8 and 0xB to 0xF change no channel state. Execute writes after them are ignored and execute reads return 0x00.
- R12: After reset every channel is masked, with address, count, port and mode at zero. tcPulse is low and execute reads return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ioAddr | input | 8 | I/O address of the access |
| ioWr | input | 1 | Write strobe, one cycle per byte |
| ioRd | input | 1 | Read strobe, one cycle per byte |
| ioWdata | input | 8 | Write data byte |
| ioRdata | output | 8 | Read data, combinational during ioRd |
| stepStrobe | input | NUM_CH | One-cycle transfer step per channel |
| tcPulse | output | NUM_CH | Terminal count pulse per channel |
| chMasked | output | NUM_CH | Mask state per channel |
| svcSel | input | CW | Channel shown on the service outputs |
| svcPort | output | 16 | Peripheral port of the selected channel |
| svcEnable | output | 1 | Transfer enable flag of the selected channel |
| svcRead | output | 1 | Read direction flag of the selected channel |
| svcIoMode | output | 1 | I/O-port mode flag of the selected channel |
| svcWide | output | 1 | 16-bit unit flag of the selected channel |

## Verification
A corrupted byte pointer shows on the very next execute read, which returns a byte from the wrong lane or zero. A wrong channel decode shows when a neighbouring channel's address is read back after the write. Errors in the count or address datapath stay hidden until the channel is stepped. They then show in the readback after one step, and in the cycle of the terminal count pulse and self-mask after the full programmed length.

// File: rtl/dmaProgPkg.sv
package dmaProgPkg;

  typedef enum logic [3:0] {
    OP_SET_PORT = 4'h0,
    OP_SET_ADDR = 4'h2,
    OP_GET_ADDR = 4'h3,
    OP_SET_CNT  = 4'h4,
    OP_GET_CNT  = 4'h5,
    OP_SET_MODE = 4'h7,
    OP_MASK     = 4'h9,
    OP_UNMASK   = 4'hA
  } dmaOpT;

  // strobes from the command decoder to the channel datapath
  typedef struct packed {
    logic       ldAddr;
    logic       ldCnt;
    logic       ldPort;
    logic       ldMode;
    logic       setMask;
    logic       clrMask;
    logic       rdAddr;
    logic       rdCnt;
    logic [1:0] idx;
    logic [7:0] data;
  } dmaStrobeT;

  typedef struct packed {
    logic wide;
    logic dirRead;
    logic enable;
    logic ioMode;
  } chModeT;

  // number of parameter bytes an opcode moves over the execute port
  function automatic logic [1:0] opBytes(input logic [3:0] op);
    case (op)
      OP_SET_ADDR, OP_GET_ADDR: opBytes = 2'd3;
      OP_SET_CNT, OP_GET_CNT, OP_SET_PORT: opBytes = 2'd2;
      OP_SET_MODE: opBytes = 2'd1;
      default: opBytes = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/dmaCmdCtrl.sv
module dmaCmdCtrl
  import dmaProgPkg::*;
#(
  parameter int NUM_CH = 8,
  parameter logic [7:0] CMD_ADDR = 8'h18,
  parameter logic [7:0] EXEC_ADDR = 8'h1A,
  localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [7:0]    ioAddr,
  input  logic          ioWr,
  input  logic          ioRd,
  input  logic [7:0]    ioWdata,
  output dmaStrobeT     strobe,
  output logic [CW-1:0] chanIdx
);

  logic [3:0] opQ, chanQ, selChan;
  logic [1:0] ptrQ;
  logic       cmdWr, execWr, execRd, selOk, inSeq;

  assign cmdWr   = ioWr && (ioAddr == CMD_ADDR);
  assign execWr  = ioWr && (ioAddr == EXEC_ADDR);
  assign execRd  = ioRd && !ioWr && (ioAddr == EXEC_ADDR);
  assign selChan = cmdWr ? ioWdata[3:0] : chanQ;
  assign selOk   = {1'b0, selChan} < 5'(NUM_CH);
  assign chanIdx = selChan[CW-1:0];
  assign inSeq   = ptrQ < opBytes(opQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ   <= 4'hF;
      chanQ <= 4'h0;
      ptrQ  <= 2'd0;
    end else if (cmdWr) begin
      opQ   <= ioWdata[7:4];
      chanQ <= ioWdata[3:0];
      ptrQ  <= 2'd0;
    end else if ((execWr || execRd) && ptrQ != 2'd3) begin
      ptrQ <= ptrQ + 2'd1;
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.idx     = ptrQ;
    strobe.data    = ioWdata;
    strobe.setMask = cmdWr && selOk && (ioWdata[7:4] == OP_MASK);
    strobe.clrMask = cmdWr && selOk && (ioWdata[7:4] == OP_UNMASK);
    if (!cmdWr && selOk && inSeq) begin
      strobe.ldAddr = execWr && (opQ == OP_SET_ADDR);
      strobe.ldCnt  = execWr && (opQ == OP_SET_CNT);
      strobe.ldPort = execWr && (opQ == OP_SET_PORT);
      strobe.ldMode = execWr && (opQ == OP_SET_MODE);
      strobe.rdAddr = execRd && (opQ == OP_GET_ADDR);
      strobe.rdCnt  = execRd && (opQ == OP_GET_CNT);
    end
  end

  // R8: a command write restarts the byte sequence
  p_ptr_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr |=> ptrQ == 2'd0);

  // R1: parameter loads only come from execute-port writes
  p_load_from_exec_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ldAddr || strobe.ldCnt || strobe.ldPort || strobe.ldMode)
      |-> (ioWr && ioAddr == EXEC_ADDR));

  // R11: an unimplemented opcode never produces a load or readback
  p_unimpl_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (opBytes(opQ) == 2'd0) |->
      !(strobe.ldAddr || strobe.ldCnt || strobe.ldPort || strobe.ldMode ||
        strobe.rdAddr || strobe.rdCnt));

endmodule

// File: rtl/dmaChanData.sv
module dmaChanData
  import dmaProgPkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobeT         strobe,
  input  logic [CW-1:0]     chanIdx,
  input  logic [NUM_CH-1:0] stepStrobe,
  input  logic [CW-1:0]     svcSel,
  output logic [7:0]        rdByte,
  output logic [NUM_CH-1:0] tcPulse,
  output logic [NUM_CH-1:0] chMasked,
  output logic [15:0]       svcPort,
  output chModeT            svcMode
);

  logic [23:0]       addrQ [NUM_CH];
  logic [15:0]       cntQ  [NUM_CH];
  logic [15:0]       portQ [NUM_CH];
  chModeT            modeQ [NUM_CH];
  logic [NUM_CH-1:0] maskQ, tcQ, hitVec, goVec;
  logic              anyCmd;

  assign anyCmd = strobe.ldAddr || strobe.ldCnt || strobe.ldPort ||
                  strobe.ldMode || strobe.setMask || strobe.clrMask;

  // programming a channel takes priority over a step in the same cycle
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      hitVec[c] = anyCmd && (chanIdx == CW'(c));
      goVec[c]  = stepStrobe[c] && !maskQ[c] && modeQ[c].enable && !hitVec[c];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '1;
      tcQ   <= '0;
      for (int c = 0; c < NUM_CH; c++) begin
        addrQ[c] <= '0;
        cntQ[c]  <= '0;
        portQ[c] <= '0;
        modeQ[c] <= '0;
      end
    end else begin
      tcQ <= '0;
      for (int c = 0; c < NUM_CH; c++) begin
        if (hitVec[c]) begin
          if (strobe.ldAddr) addrQ[c][{strobe.idx, 3'b000} +: 8] <= strobe.data;
          if (strobe.ldCnt)  cntQ[c][{strobe.idx[0], 3'b000} +: 8] <= strobe.data;
          if (strobe.ldPort) portQ[c][{strobe.idx[0], 3'b000} +: 8] <= strobe.data;
          if (strobe.ldMode) modeQ[c] <= {strobe.data[6], strobe.data[3],
                                          strobe.data[2], strobe.data[0]};
          if (strobe.setMask) maskQ[c] <= 1'b1;
          if (strobe.clrMask) maskQ[c] <= 1'b0;
        end else if (goVec[c]) begin
          addrQ[c] <= addrQ[c] + (modeQ[c].wide ? 24'd2 : 24'd1);
          if (cntQ[c] == 16'd0) begin
            cntQ[c]  <= 16'hFFFF;
            maskQ[c] <= 1'b1;
            tcQ[c]   <= 1'b1;
          end else begin
            cntQ[c] <= cntQ[c] - 16'd1;
          end
        end
      end
    end
  end

  always_comb begin
    rdByte = 8'h00;
    if (strobe.rdAddr)     rdByte = addrQ[chanIdx][{strobe.idx, 3'b000} +: 8];
    else if (strobe.rdCnt) rdByte = cntQ[chanIdx][{strobe.idx[0], 3'b000} +: 8];
  end

  assign tcPulse  = tcQ;
  assign chMasked = maskQ;
  assign svcPort  = portQ[svcSel];
  assign svcMode  = modeQ[svcSel];

  // R7: an unmask command clears the addressed mask bit
  p_unmask_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrMask |=> !maskQ[$past(chanIdx)]);

  for (genvar g = 0; g < NUM_CH; g++) begin : gChk
    // R10: terminal count leaves the channel masked with an all-ones count
    p_tc_masks_r10: assert property (@(posedge clk) disable iff (!rstN)
      tcQ[g] |-> (maskQ[g] && cntQ[g] == 16'hFFFF));
    // R9: a step on a masked channel leaves its address alone
    p_masked_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
      (stepStrobe[g] && maskQ[g] && !hitVec[g]) |=> $stable(addrQ[g]));
  end

endmodule

// File: rtl/dmaProgTop.sv
module dmaProgTop
  import dmaProgPkg::*;
#(
  parameter int NUM_CH = 8,
  parameter logic [7:0] CMD_ADDR = 8'h18,
  parameter logic [7:0] EXEC_ADDR = 8'h1A,
  localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [7:0]        ioWdata,
  output logic [7:0]        ioRdata,
  input  logic [NUM_CH-1:0] stepStrobe,
  output logic [NUM_CH-1:0] tcPulse,
  output logic [NUM_CH-1:0] chMasked,
  input  logic [CW-1:0]     svcSel,
  output logic [15:0]       svcPort,
  output logic              svcEnable,
  output logic              svcRead,
  output logic              svcIoMode,
  output logic              svcWide
);

  dmaStrobeT     strobe;
  logic [CW-1:0] chanIdx;
  chModeT        svcMode;

  dmaCmdCtrl #(.NUM_CH(NUM_CH), .CMD_ADDR(CMD_ADDR), .EXEC_ADDR(EXEC_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
    .ioWdata(ioWdata), .strobe(strobe), .chanIdx(chanIdx)
  );

  dmaChanData #(.NUM_CH(NUM_CH)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .chanIdx(chanIdx),
    .stepStrobe(stepStrobe), .svcSel(svcSel), .rdByte(ioRdata),
    .tcPulse(tcPulse), .chMasked(chMasked), .svcPort(svcPort), .svcMode(svcMode)
  );

  assign svcEnable = svcMode.enable;
  assign svcRead   = svcMode.dirRead;
  assign svcIoMode = svcMode.ioMode;
  assign svcWide   = svcMode.wide;

endmodule

// File: tb/tb_dmaProgTop.sv
module tb_dmaProgTop;

  localparam int NCH = 8;
  localparam int CW = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic [7:0] ioAddr = '0, ioWdata = '0, ioRdata;
  logic ioWr = 1'b0, ioRd = 1'b0;
  logic [NCH-1:0] stepStrobe = '0, tcPulse, chMasked;
  logic [CW-1:0] svcSel = '0;
  logic [15:0] svcPort;
  logic svcEnable, svcRead, svcIoMode, svcWide;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  dmaProgTop #(.NUM_CH(NCH)) dut (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
    .ioWdata(ioWdata), .ioRdata(ioRdata), .stepStrobe(stepStrobe),
    .tcPulse(tcPulse), .chMasked(chMasked), .svcSel(svcSel), .svcPort(svcPort),
    .svcEnable(svcEnable), .svcRead(svcRead), .svcIoMode(svcIoMode), .svcWide(svcWide)
  );

  // entry: {req[3:0], kind[1:0] (1 write, 2 read-check), addr[7:0], data[7:0]}
  localparam int NV = 44;
  localparam logic [21:0] VEC [NV] = '{
    {4'd7, 2'd1, 8'h18, 8'h91},  // R7 mask ch1
    {4'd3, 2'd1, 8'h18, 8'h21},  // R3 set address ch1
    {4'd3, 2'd1, 8'h1A, 8'h56},
    {4'd3, 2'd1, 8'h1A, 8'h34},
    {4'd3, 2'd1, 8'h1A, 8'h12},
    {4'd8, 2'd1, 8'h1A, 8'hFF},  // R8 surplus byte
    {4'd3, 2'd1, 8'h18, 8'h31},
    {4'd3, 2'd2, 8'h1A, 8'h56},
    {4'd3, 2'd2, 8'h1A, 8'h34},
    {4'd3, 2'd2, 8'h1A, 8'h12},
    {4'd8, 2'd2, 8'h1A, 8'h00},  // R8 read past length
    {4'd4, 2'd1, 8'h18, 8'h41},  // R4 count ch1 = 3
    {4'd4, 2'd1, 8'h1A, 8'h03},
    {4'd4, 2'd1, 8'h1A, 8'h00},
    {4'd4, 2'd1, 8'h18, 8'h51},
    {4'd4, 2'd2, 8'h1A, 8'h03},
    {4'd4, 2'd2, 8'h1A, 8'h00},
    {4'd8, 2'd2, 8'h1A, 8'h00},
    {4'd7, 2'd1, 8'h18, 8'h92},
    {4'd8, 2'd1, 8'h18, 8'h22},  // R8 partial sequence on ch2
    {4'd8, 2'd1, 8'h1A, 8'hAA},
    {4'd8, 2'd1, 8'h18, 8'h32},
    {4'd8, 2'd2, 8'h1A, 8'hAA},
    {4'd8, 2'd2, 8'h1A, 8'h00},
    {4'd3, 2'd1, 8'h18, 8'h31},
    {4'd3, 2'd2, 8'h1A, 8'h56},
    {4'd1, 2'd1, 8'h19, 8'h31},  // R1 stray address ignored
    {4'd1, 2'd2, 8'h1A, 8'h34},
    {4'd11, 2'd1, 8'h18, 8'h61}, // R11 unimplemented opcode
    {4'd11, 2'd1, 8'h1A, 8'h77},
    {4'd11, 2'd1, 8'h18, 8'h31},
    {4'd11, 2'd2, 8'h1A, 8'h56},
    {4'd11, 2'd1, 8'h18, 8'hF1},
    {4'd11, 2'd2, 8'h1A, 8'h00},
    {4'd2, 2'd1, 8'h18, 8'h29},  // R2 channel 9 out of range
    {4'd2, 2'd1, 8'h1A, 8'hEE},
    {4'd2, 2'd1, 8'h18, 8'h31},
    {4'd2, 2'd2, 8'h1A, 8'h56},
    {4'd5, 2'd1, 8'h18, 8'h01},  // R5 port ch1 = 0xABCD
    {4'd5, 2'd1, 8'h1A, 8'hCD},
    {4'd5, 2'd1, 8'h1A, 8'hAB},
    {4'd6, 2'd1, 8'h18, 8'h71},  // R6 mode enable + read
    {4'd6, 2'd1, 8'h1A, 8'h0C},
    {4'd7, 2'd1, 8'h18, 8'hA1}   // R7 unmask ch1
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    ioWr = 1'b1; ioAddr = a; ioWdata = d;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [7:0] exp);
    @(negedge clk);
    ioRd = 1'b1; ioAddr = 8'h1A;
    #1;
    chk(tag, 32'(ioRdata), 32'(exp));
    @(negedge clk);
    ioRd = 1'b0;
  endtask

  task automatic step(input int ch);
    @(negedge clk);
    stepStrobe = NCH'(1) << ch;
    @(negedge clk);
    stepStrobe = '0;
  endtask

  task automatic runAll();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R12 reset state
    chk("R12 mask after reset", 32'(chMasked), 32'hFF);
    chk("R12 tc after reset", 32'(tcPulse), 32'h0);
    rdChk("R12 read after reset", 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][17:16] == 2'd1) wr(VEC[i][15:8], VEC[i][7:0]);
      else if (VEC[i][17:16] == 2'd2)
        rdChk($sformatf("R%0d table[%0d]", VEC[i][21:18], i), VEC[i][7:0]);
    end

    @(negedge clk);
    svcSel = 3'd1;
    #1;
    chk("R5 port", 32'(svcPort), 32'hABCD);
    chk("R6 mode flags", {28'd0, svcEnable, svcRead, svcIoMode, svcWide}, 32'b1100);
    chk("R7 unmasked", 32'(chMasked[1]), 32'd1 - 32'd1);

    // R9 single step on ch1
    step(1);
    chk("R10 no tc yet", 32'(tcPulse), 32'h0);
    wr(8'h18, 8'h31);
    rdChk("R9 addr +1", 8'h57);
    wr(8'h18, 8'h51);
    rdChk("R9 count -1", 8'h02);
    step(1); step(1);
    chk("R10 no tc early", 32'(tcPulse), 32'h0);
    step(1);
    chk("R10 tc pulse", 32'(tcPulse), 32'h02);
    chk("R10 self mask", 32'(chMasked[1]), 32'd1);
    @(negedge clk);
    chk("R10 tc one cycle", 32'(tcPulse), 32'h0);
    wr(8'h18, 8'h51);
    rdChk("R10 count wrap lo", 8'hFF);
    rdChk("R10 count wrap hi", 8'hFF);
    step(1);
    wr(8'h18, 8'h31);
    rdChk("R9 masked step idle", 8'h5A);

    // 16-bit mode on ch3
    wr(8'h18, 8'h93);
    wr(8'h18, 8'h23); wr(8'h1A, 8'hFF); wr(8'h1A, 8'hFF); wr(8'h1A, 8'h00);
    wr(8'h18, 8'h43); wr(8'h1A, 8'h01); wr(8'h1A, 8'h00);
    wr(8'h18, 8'h73); wr(8'h1A, 8'h45);
    @(negedge clk);
    svcSel = 3'd3;
    #1;
    chk("R6 wide io write", {28'd0, svcEnable, svcRead, svcIoMode, svcWide}, 32'b1011);
    wr(8'h18, 8'hA3);
    step(3);
    chk("R10 ch3 no tc", 32'(tcPulse), 32'h0);
    step(3);
    chk("R10 ch3 tc", 32'(tcPulse), 32'h08);
    wr(8'h18, 8'h33);
    rdChk("R9 wide addr b0", 8'h03);
    rdChk("R9 wide addr b1", 8'h00);
    rdChk("R9 wide addr b2", 8'h01);

    // R9 disabled channel ignores steps
    wr(8'h18, 8'h74); wr(8'h1A, 8'h00); wr(8'h18, 8'hA4);
    step(4);
    chk("R9 disabled no tc", 32'(tcPulse), 32'h0);
    chk("R9 disabled stays unmasked", 32'(chMasked[4]), 32'h0);
    wr(8'h18, 8'h54);
    rdChk("R9 disabled count", 8'h00);

    // R12 reset in mid run
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    chk("R12 mask after rerun", 32'(chMasked), 32'hFF);
    wr(8'h18, 8'h31);
    rdChk("R12 addr cleared", 8'h00);
  endtask

  initial begin
    fork
      runAll();
      begin
        #500us;
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule